// File: doc/BRIEF.md
# Shared-Memory Command Ring Parser

This block drains a circular queue of 32-bit command words held in a dedicated word-wide memory. The first four words of that memory form the ring header, in this order: the lowest usable byte offset (floor), the wrap byte offset (ceiling), the producer offset, and the consumer offset. When the host raises the configuration-done level, the parser reads all four header words. It accepts the ring only if every header word is 4-byte aligned, the floor lies past the 16-byte header, the ceiling is no larger than the memory and the ring spans at least 10240 bytes. The consumer offset is loaded from the header at that point.

A pulse on `sync` starts a drain. The parser repeatedly reads the producer word. While the producer differs from its consumer offset, it reads an opcode and its argument words. It hands rectangle fills and copies to a blitter and update rectangles to a redraw queue. Commands it recognises but does not execute are stepped over by their known word counts, so the ring stays aligned with the producer. After each command, the new consumer offset is written back to header word 3. An opcode outside the known set stops the parser and raises a sticky error flag, which the host can read.

Top module: `ring_cmd_parser`

## Requirements
- R1: A rising edge of `cfg_done` reads header words 0..3 (floor, ceiling, producer, consumer). The ring is rejected if any of the four is not a multiple of 4, if floor < 16, if ceiling > 0x10000, or if ceiling < floor + 10240. A rejected ring never consumes a word on `sync`.
- R2: The ring counts as empty, and nothing is consumed, when the producer word equals the consumer offset, when `enable` is low, or when `cfg_done` is low.
- R3: Each word read advances the consumer offset by 4 bytes. If the result is at or above the ceiling, it becomes the floor. After every completed command, the consumer offset is written to header word 3 (byte offset 12).
- R4: Opcodes 1 and 25 take 4 argument words (x, y, w, h). They raise `redraw_vld` for one cycle with `cmd_args[0..3]` holding those words in order.
- R5: Opcode 2 takes 5 words (colour, x, y, w, h). It raises `fill_vld` for one cycle with `cmd_args[0..4]` holding them in order.
- R6: Opcode 3 takes 6 words (source x, source y, destination x, destination y, w, h). It raises `copy_vld` for one cycle with `cmd_args[0..5]` holding them in order.
- R7: The following opcodes consume the opcode word and then a fixed number of further words, with no dispatch: opcode 0 consumes 0, opcode 13 consumes 6, opcode 14 consumes 7 and opcode 28 consumes 12.
- R8: Opcode 19 consumes 6 header words (id, hot x, hot y, w, h, bpp). It then consumes ceil(w/32)*h mask words and ceil(w*bpp/32)*h image words, using the low 12 bits of w, h and bpp. It dispatches nothing, whatever the size.
- R9: Opcode 22 consumes 5 header words (id, hot x, hot y, w, h) and then w*h words. Opcode 24 reads one word n and then consumes a further 7 + n/4 words.
- R10: Any other opcode halts the parser and sets `err_flag`. The consumer offset is not written back. Later `sync` pulses have no effect, and the flag holds until the next rising edge of `cfg_done`.
- R11: A fill or copy is not dispatched while `blit_busy` is high. A fill or copy pulse never follows a cycle in which `blit_busy` was high.
- R12: After reset all pulses, memory strobes and `err_flag` are low. A `sync` pulse on a valid, enabled ring drains every command up to the producer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Device enable level |
| cfg_done | input | 1 | Configuration-done level; a rising edge loads the header |
| sync | input | 1 | One-cycle pulse that starts a drain |
| blit_busy | input | 1 | Blitter cannot take a fill or copy |
| mem_rd | output | 1 | Ring memory read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Ring memory write strobe |
| mem_addr | output | AW (14) | Ring memory word address |
| mem_wdata | output | 32 | Ring memory write data |
| mem_rdata | input | 32 | Ring memory read data |
| fill_vld | output | 1 | Rectangle fill pulse |
| copy_vld | output | 1 | Rectangle copy pulse |
| redraw_vld | output | 1 | Update rectangle pulse |
| cmd_args | output | 6x32 | Argument words of the dispatched command, index 0 first |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
A `sync` pulse can arrive in the same cycle in which the parser is stalled on a fill with a busy blitter. In that case the new request and the pending dispatch meet. The bench provokes this by holding `blit_busy` high over a fill and pulsing `sync` during the stall. It then judges the outcome at the ports. The stall must end with exactly one fill pulse, carrying the right arguments. The consumer word in memory must advance once, to the producer. No second dispatch may follow. The dispatch pulse itself always falls in the same cycle as the consumer write-back, and an assertion watches that pairing.

// File: rtl/ring_pkg.sv
// Package: shared types and constants of the command ring parser.
// Assumes 32-bit ring words and at most six captured argument words.
package ring_pkg;
    localparam int WORD = 32;
    localparam int ARGS = 6;
    localparam int HDR_PROD = 2;
    localparam int HDR_CONS = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CFG_RD, ST_CFG_CAP, ST_CFG_EVAL,
        ST_PROD_RD, ST_PROD_CAP, ST_OP_RD, ST_OP_CAP,
        ST_ARG_RD, ST_ARG_CAP, ST_POST, ST_SKIP, ST_WB, ST_HALT
    } pstate_e;

    typedef enum logic [2:0] {
        K_NONE, K_UPDATE, K_FILL, K_COPY, K_CURSOR, K_ALPHA_CUR, K_GLYPH
    } kind_e;
endpackage

// File: rtl/ring_op_decode.sv
// Opcode decoder: maps an opcode word to its kind, number of captured
// argument words and fixed number of further words to skip.
// Assumes the caller treats known == 0 as an unrecognised opcode.
module ring_op_decode
    import ring_pkg::*;
(
    input  logic [WORD-1:0] op,
    output logic            known,
    output kind_e           kind,
    output logic [2:0]      nargs,
    output logic [3:0]      fskip
);
    // Purpose: table lookup of the opcode properties.
    always_comb begin
        known = 1'b1;
        kind  = K_NONE;
        nargs = 3'd0;
        fskip = 4'd0;
        case (op)
            32'd0:         ;
            32'd1, 32'd25: begin kind = K_UPDATE;    nargs = 3'd4; end
            32'd2:         begin kind = K_FILL;      nargs = 3'd5; end
            32'd3:         begin kind = K_COPY;      nargs = 3'd6; end
            32'd13:        fskip = 4'd6;
            32'd14:        fskip = 4'd7;
            32'd28:        fskip = 4'd12;
            32'd19:        begin kind = K_CURSOR;    nargs = 3'd6; end
            32'd22:        begin kind = K_ALPHA_CUR; nargs = 3'd5; end
            32'd24:        begin kind = K_GLYPH;     nargs = 3'd1; end
            default:       known = 1'b0;
        endcase
    end
endmodule

// File: rtl/ring_hdr_check.sv
// Header validator: decides whether the four header words describe a
// usable ring. Purely combinational; the caller registers the result.
module ring_hdr_check #(
    parameter int RING_BYTES = 65536,
    parameter int HDR_BYTES  = 16,
    parameter int MIN_SPAN   = 10240
) (
    input  logic [31:0] floor_off,
    input  logic [31:0] ceil_off,
    input  logic [31:0] prod_off,
    input  logic [31:0] cons_off,
    output logic        ok
);
    logic [32:0] need_ceil;
    logic        aligned;

    // Purpose: alignment, placement and span rules in one expression.
    always_comb begin
        need_ceil = {1'b0, floor_off} + 33'(MIN_SPAN);
        aligned   = ((floor_off | ceil_off | prod_off | cons_off) & 32'd3) == 32'd0;
        ok = aligned
            && (floor_off >= 32'(HDR_BYTES))
            && ({1'b0, ceil_off} <= 33'(RING_BYTES))
            && ({1'b0, ceil_off} >= need_ceil);
    end
endmodule

// File: rtl/ring_ptr_step.sv
// Consumer step: advances a byte offset by one word, wrapping to the
// floor when the result reaches or passes the ceiling.
module ring_ptr_step (
    input  logic [31:0] cur,
    input  logic [31:0] floor_off,
    input  logic [31:0] ceil_off,
    output logic [31:0] nxt
);
    logic [32:0] sum;

    // Purpose: add four bytes and wrap.
    always_comb begin
        sum = {1'b0, cur} + 33'd4;
        nxt = (sum >= {1'b0, ceil_off}) ? floor_off : sum[31:0];
    end
endmodule

// File: rtl/ring_skip_calc.sv
// Payload length: computes the variable number of words that follow the
// captured arguments of the cursor, alpha cursor and glyph commands.
// Assumes the dimensions fit in DIM_W bits; higher bits are ignored.
module ring_skip_calc
    import ring_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int SKW   = 36
) (
    input  kind_e                      kind,
    input  logic [ARGS-1:0][WORD-1:0]  args,
    output logic [SKW-1:0]             dyn
);
    logic [DIM_W-1:0] w, h, bpp;
    logic [SKW-1:0]   mask_cols, img_bits, mask_w, img_w;

    // Purpose: derive mask, image, alpha and glyph payload sizes.
    always_comb begin
        w         = args[3][DIM_W-1:0];
        h         = args[4][DIM_W-1:0];
        bpp       = args[5][DIM_W-1:0];
        mask_cols = (SKW'(w) + SKW'(31)) >> 5;
        img_bits  = SKW'(w) * SKW'(bpp) + SKW'(31);
        mask_w    = mask_cols * SKW'(h);
        img_w     = (img_bits >> 5) * SKW'(h);
        case (kind)
            K_CURSOR:    dyn = mask_w + img_w;
            K_ALPHA_CUR: dyn = SKW'(w) * SKW'(h);
            K_GLYPH:     dyn = SKW'(args[0] >> 2) + SKW'(7);
            default:     dyn = '0;
        endcase
    end
endmodule

// File: rtl/ring_cmd_parser.sv
// Command ring parser top: loads and validates the ring header, then on
// sync drains commands between the consumer and producer offsets. It
// dispatches fill, copy and update commands, skips the other known
// commands and halts on an unknown opcode. Assumes a memory with
// one-cycle read latency that is not written by the host during a drain
// except at the producer word.
module ring_cmd_parser
    import ring_pkg::*;
#(
    parameter int RING_BYTES = 65536,
    parameter int HDR_BYTES  = 16,
    parameter int MIN_SPAN   = 10240,
    parameter int DIM_W      = 12,
    localparam int AW        = $clog2(RING_BYTES / 4)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      cfg_done,
    input  logic                      sync,
    input  logic                      blit_busy,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [AW-1:0]             mem_addr,
    output logic [WORD-1:0]           mem_wdata,
    input  logic [WORD-1:0]           mem_rdata,
    output logic                      fill_vld,
    output logic                      copy_vld,
    output logic                      redraw_vld,
    output logic [ARGS-1:0][WORD-1:0] cmd_args,
    output logic                      err_flag
);
    localparam int SKW = (3 * DIM_W > 33) ? 3 * DIM_W : 34;

    pstate_e                   state_q;
    logic                      cfg_q, pend_q, ok_q, err_q;
    logic [1:0]                hidx_q;
    logic [3:0][WORD-1:0]      hdr_q;
    logic [WORD-1:0]           floor_q, ceil_q, cons_q;
    kind_e                     kind_q;
    logic [2:0]                need_q, argc_q;
    logic [3:0]                fskip_q;
    logic [ARGS-1:0][WORD-1:0] args_q;
    logic [SKW-1:0]            skip_q;
    logic                      fill_q, copy_q, upd_q;

    logic            cfg_rise, ring_on, hdr_ok, dec_known;
    kind_e           dec_kind;
    logic [2:0]      dec_nargs;
    logic [3:0]      dec_fskip;
    logic [WORD-1:0] cons_nxt;
    logic [SKW-1:0]  dyn_skip, tot_skip;

    ring_op_decode i_dec (
        .op(mem_rdata), .known(dec_known), .kind(dec_kind),
        .nargs(dec_nargs), .fskip(dec_fskip)
    );

    ring_hdr_check #(.RING_BYTES(RING_BYTES), .HDR_BYTES(HDR_BYTES),
                     .MIN_SPAN(MIN_SPAN)) i_hdr (
        .floor_off(hdr_q[0]), .ceil_off(hdr_q[1]),
        .prod_off(hdr_q[2]), .cons_off(hdr_q[3]), .ok(hdr_ok)
    );

    ring_ptr_step i_step (
        .cur(cons_q), .floor_off(floor_q), .ceil_off(ceil_q), .nxt(cons_nxt)
    );

    ring_skip_calc #(.DIM_W(DIM_W), .SKW(SKW)) i_skip (
        .kind(kind_q), .args(args_q), .dyn(dyn_skip)
    );

    // Purpose: edge detect, ring readiness and total skip length.
    always_comb begin
        cfg_rise = cfg_done & ~cfg_q;
        ring_on  = enable & cfg_done & ok_q;
        tot_skip = dyn_skip + SKW'(fskip_q);
    end

    // Purpose: memory strobes and address per state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = cons_q;
        case (state_q)
            ST_CFG_RD:  begin mem_rd = 1'b1; mem_addr = AW'(hidx_q); end
            ST_PROD_RD: begin mem_rd = 1'b1; mem_addr = AW'(HDR_PROD); end
            ST_OP_RD,
            ST_ARG_RD:  begin mem_rd = 1'b1; mem_addr = cons_q[AW+1:2]; end
            ST_WB:      begin mem_wr = 1'b1; mem_addr = AW'(HDR_CONS); end
            default:    ;
        endcase
    end

    // Purpose: parser sequencer, header capture and dispatch pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= 1'b0;
            pend_q  <= 1'b0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
            hidx_q  <= '0;
            hdr_q   <= '0;
            floor_q <= '0;
            ceil_q  <= '0;
            cons_q  <= '0;
            kind_q  <= K_NONE;
            need_q  <= '0;
            argc_q  <= '0;
            fskip_q <= '0;
            args_q  <= '0;
            skip_q  <= '0;
            fill_q  <= 1'b0;
            copy_q  <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            cfg_q  <= cfg_done;
            fill_q <= 1'b0;
            copy_q <= 1'b0;
            upd_q  <= 1'b0;
            if (sync) pend_q <= 1'b1;
            if (cfg_rise && (state_q == ST_IDLE || state_q == ST_HALT)) begin
                state_q <= ST_CFG_RD;
                hidx_q  <= '0;
                err_q   <= 1'b0;
                ok_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (pend_q && ring_on) state_q <= ST_PROD_RD;
                        else if (pend_q)       pend_q  <= sync;
                    end
                    ST_CFG_RD:  state_q <= ST_CFG_CAP;
                    ST_CFG_CAP: begin
                        hdr_q[hidx_q] <= mem_rdata;
                        hidx_q        <= hidx_q + 2'd1;
                        state_q       <= (hidx_q == 2'd3) ? ST_CFG_EVAL : ST_CFG_RD;
                    end
                    ST_CFG_EVAL: begin
                        ok_q    <= hdr_ok;
                        floor_q <= hdr_q[0];
                        ceil_q  <= hdr_q[1];
                        cons_q  <= hdr_q[3];
                        state_q <= ST_IDLE;
                    end
                    ST_PROD_RD: state_q <= ST_PROD_CAP;
                    ST_PROD_CAP: begin
                        if (mem_rdata == cons_q || !ring_on) begin
                            state_q <= ST_IDLE;
                            pend_q  <= sync;
                        end else begin
                            state_q <= ST_OP_RD;
                        end
                    end
                    ST_OP_RD: state_q <= ST_OP_CAP;
                    ST_OP_CAP: begin
                        if (!dec_known) begin
                            state_q <= ST_HALT;
                            err_q   <= 1'b1;
                        end else begin
                            cons_q  <= cons_nxt;
                            kind_q  <= dec_kind;
                            need_q  <= dec_nargs;
                            fskip_q <= dec_fskip;
                            argc_q  <= '0;
                            state_q <= (dec_nargs == 3'd0) ? ST_POST : ST_ARG_RD;
                        end
                    end
                    ST_ARG_RD: state_q <= ST_ARG_CAP;
                    ST_ARG_CAP: begin
                        args_q[argc_q] <= mem_rdata;
                        cons_q         <= cons_nxt;
                        argc_q         <= argc_q + 3'd1;
                        state_q        <= (argc_q + 3'd1 == need_q) ? ST_POST : ST_ARG_RD;
                    end
                    ST_POST: begin
                        case (kind_q)
                            K_FILL, K_COPY: begin
                                if (!blit_busy) begin
                                    fill_q  <= (kind_q == K_FILL);
                                    copy_q  <= (kind_q == K_COPY);
                                    state_q <= ST_WB;
                                end
                            end
                            K_UPDATE: begin
                                upd_q   <= 1'b1;
                                state_q <= ST_WB;
                            end
                            default: begin
                                skip_q  <= tot_skip;
                                state_q <= (tot_skip == '0) ? ST_WB : ST_SKIP;
                            end
                        endcase
                    end
                    ST_SKIP: begin
                        cons_q <= cons_nxt;
                        skip_q <= skip_q - SKW'(1);
                        if (skip_q == SKW'(1)) state_q <= ST_WB;
                    end
                    ST_WB:   state_q <= ST_PROD_RD;
                    ST_HALT: ;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign fill_vld   = fill_q;
    assign copy_vld   = copy_q;
    assign redraw_vld = upd_q;
    assign cmd_args   = args_q;
    assign err_flag   = err_q;
endmodule

// File: rtl/ring_cmd_parser_chk.sv
// Checker for the command ring parser: port-level timing rules of the
// write-back, the dispatch pulses, the blitter stall and the error halt.
module ring_cmd_parser_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_done,
    input logic          blit_busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          fill_vld,
    input logic          copy_vld,
    input logic          redraw_vld,
    input logic          err_flag
);
    // R3: write-back goes only to the consumer word, aligned, never with a read
    p_wb_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == AW'(3) && mem_wdata[1:0] == 2'b00 && !mem_rd));

    // R3: each dispatch coincides with the consumer write-back
    p_dispatch_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld || copy_vld || redraw_vld) |-> mem_wr);

    // R4: at most one dispatch pulse at a time
    p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_vld, copy_vld, redraw_vld}));

    // R11: no blitter pulse after a busy cycle
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld || copy_vld) |-> !$past(blit_busy));

    // R10: the error flag holds until configuration is raised again
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !cfg_done) |=> err_flag);

    // R10: a halted parser neither writes nor dispatches
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !(mem_wr || fill_vld || copy_vld || redraw_vld));
endmodule

bind ring_cmd_parser ring_cmd_parser_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_ring_cmd_parser.sv
// Bench for the command ring parser: a vector table of commands walked by
// one loop, then directed tests for reset, empty, stall, wrap, bad header
// and unknown-opcode halt.
module test_ring_cmd_parser;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam logic [31:0] FLOOR = 32'd16;
    localparam logic [31:0] CEIL  = 32'd10256;

    typedef struct packed {
        logic [31:0]       op;
        logic [0:5][31:0]  a;
        logic [15:0]       n;
        logic [1:0]        kind;
    } vec_t;

    // kind: 0 none, 1 fill, 2 copy, 3 redraw; n = total words consumed
    localparam vec_t VT [0:11] = '{
        '{32'd1,  '{32'd10, 32'd20, 32'd30, 32'd40, 32'd0, 32'd0}, 16'd5, 2'd3},
        '{32'd25, '{32'd1, 32'd2, 32'd3, 32'd4, 32'd0, 32'd0}, 16'd5, 2'd3},
        '{32'd2,  '{32'hAABBCC, 32'd5, 32'd6, 32'd7, 32'd8, 32'd0}, 16'd6, 2'd1},
        '{32'd3,  '{32'd11, 32'd12, 32'd13, 32'd14, 32'd15, 32'd16}, 16'd7, 2'd2},
        '{32'd0,  '{32'd9, 32'd9, 32'd9, 32'd9, 32'd9, 32'd9}, 16'd1, 2'd0},
        '{32'd13, '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6}, 16'd7, 2'd0},
        '{32'd14, '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6}, 16'd8, 2'd0},
        '{32'd28, '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6}, 16'd13, 2'd0},
        '{32'd19, '{32'd7, 32'd1, 32'd1, 32'd40, 32'd2, 32'd1}, 16'd15, 2'd0},
        '{32'd19, '{32'd7, 32'd0, 32'd0, 32'd64, 32'd600, 32'd1}, 16'd2407, 2'd0},
        '{32'd22, '{32'd1, 32'd0, 32'd0, 32'd3, 32'd5, 32'd0}, 16'd21, 2'd0},
        '{32'd24, '{32'd20, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}, 16'd14, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic cfg_done = 1'b0;
    logic sync = 1'b0;
    logic blit_busy = 1'b0;
    logic mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic fill_vld, copy_vld, redraw_vld, err_flag;
    logic [5:0][31:0] cmd_args;

    logic        tb_we = 1'b0;
    logic [11:0] tb_a = '0;
    logic [31:0] tb_d = '0;
    logic [31:0] mem [0:4095];

    int n_chk = 0;
    int n_bad = 0;
    int fill_n = 0, copy_n = 0, upd_n = 0;
    logic [31:0] bmin = FLOOR, bmax = CEIL, cur = FLOOR, exp_cons = FLOOR;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_cmd_parser i_ring_cmd_parser (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_done(cfg_done),
        .sync(sync), .blit_busy(blit_busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fill_vld(fill_vld), .copy_vld(copy_vld), .redraw_vld(redraw_vld),
        .cmd_args(cmd_args), .err_flag(err_flag)
    );

    // ring memory with one-cycle read latency
    always @(posedge clk) begin
        if (tb_we)  mem[tb_a] <= tb_d;
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    // pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (fill_vld)   fill_n <= fill_n + 1;
        if (copy_vld)   copy_n <= copy_n + 1;
        if (redraw_vld) upd_n  <= upd_n + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] o);
        return (o + 32'd4 >= bmax) ? bmin : o + 32'd4;
    endfunction

    function automatic string tag_of(input logic [31:0] op);
        case (op)
            32'd1, 32'd25:  return "R4";
            32'd2:          return "R5";
            32'd3:          return "R6";
            32'd19:         return "R8";
            32'd22, 32'd24: return "R9";
            default:        return "R7";
        endcase
    endfunction

    task automatic put_word(input logic [31:0] off, input logic [31:0] val);
        tb_we = 1'b1;
        tb_a  = off[13:2];
        tb_d  = val;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic pulse_sync();
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
    endtask

    task automatic do_cfg(input logic [31:0] mn, input logic [31:0] mx,
                          input logic [31:0] pr, input logic [31:0] cs);
        cfg_done = 1'b0;
        put_word(0, mn);
        put_word(4, mx);
        put_word(8, pr);
        put_word(12, cs);
        @(negedge clk);
        cfg_done = 1'b1;
        repeat (20) @(negedge clk);
        bmin = mn;
        bmax = mx;
        cur  = cs;
    endtask

    task automatic push(input logic [31:0] op, input logic [0:5][31:0] a,
                        input int n);
        logic [31:0] o;
        logic [31:0] p;
        o = cur;
        put_word(o, op);
        o = nxt(o);
        for (int j = 0; j < 6; j++) begin
            put_word(o, a[j]);
            o = nxt(o);
        end
        p = cur;
        for (int j = 0; j < n; j++) p = nxt(p);
        put_word(8, p);
        exp_cons = p;
        cur = p;
        pulse_sync();
    endtask

    task automatic wait_cons(input logic [31:0] exp, input int lim);
        for (int k = 0; k < lim; k++) begin
            if (mem[3] == exp) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0, c0, u0;
        logic [31:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk({fill_vld, copy_vld, redraw_vld, err_flag, mem_wr} == 5'b0, "R12 reset outputs",
            {27'd0, fill_vld, copy_vld, redraw_vld, err_flag, mem_wr}, 32'd0);

        do_cfg(FLOOR, CEIL, FLOOR, FLOOR);

        // table of commands walked in one loop
        for (int i = 0; i < 12; i++) begin
            f0 = fill_n; c0 = copy_n; u0 = upd_n;
            push(VT[i].op, VT[i].a, int'(VT[i].n));
            wait_cons(exp_cons, 5000);
            chk(mem[3] == exp_cons, {"R3 consumer after ", tag_of(VT[i].op)}, mem[3], exp_cons);
            chk((fill_n - f0) == (VT[i].kind == 2'd1 ? 1 : 0) &&
                (copy_n - c0) == (VT[i].kind == 2'd2 ? 1 : 0) &&
                (upd_n - u0)  == (VT[i].kind == 2'd3 ? 1 : 0),
                {tag_of(VT[i].op), " dispatch count"},
                32'(fill_n - f0 + copy_n - c0 + upd_n - u0),
                32'(VT[i].kind != 2'd0 ? 1 : 0));
            if (VT[i].kind != 2'd0) begin
                for (int j = 0; j < 6; j++) begin
                    if (j < (VT[i].kind == 2'd3 ? 4 : (VT[i].kind == 2'd1 ? 5 : 6)))
                        chk(cmd_args[j] == VT[i].a[j], {tag_of(VT[i].op), " argument"},
                            cmd_args[j], VT[i].a[j]);
                end
            end
        end

        // R2: enable low keeps the ring empty; R12: sync then drains it
        enable = 1'b0;
        held = mem[3];
        f0 = fill_n;
        push(32'd2, '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd0}, 6);
        repeat (60) @(negedge clk);
        chk(mem[3] == held && fill_n == f0, "R2 disabled ring untouched", mem[3], held);
        enable = 1'b1;
        pulse_sync();
        wait_cons(exp_cons, 200);
        chk(mem[3] == exp_cons && fill_n == f0 + 1, "R12 sync drains", mem[3], exp_cons);

        // R11: stall on busy blitter, with a sync landing during the stall
        blit_busy = 1'b1;
        held = mem[3];
        f0 = fill_n;
        push(32'd2, '{32'h123456, 32'd9, 32'd8, 32'd7, 32'd6, 32'd0}, 6);
        repeat (30) @(negedge clk);
        pulse_sync();
        repeat (10) @(negedge clk);
        chk(fill_n == f0 && mem[3] == held, "R11 no fill while busy", 32'(fill_n - f0), 32'd0);
        blit_busy = 1'b0;
        wait_cons(exp_cons, 200);
        repeat (20) @(negedge clk);
        chk(fill_n == f0 + 1, "R11 single fill after release", 32'(fill_n - f0), 32'd1);
        chk(mem[3] == exp_cons, "R11 consumer after release", mem[3], exp_cons);
        chk(cmd_args[0] == 32'h123456, "R5 colour after stall", cmd_args[0], 32'h123456);

        // R3: wrap from the ceiling back to the floor
        do_cfg(FLOOR, CEIL, CEIL - 32'd8, CEIL - 32'd8);
        f0 = fill_n;
        push(32'd2, '{32'hC0FFEE, 32'd21, 32'd22, 32'd23, 32'd24, 32'd0}, 6);
        wait_cons(exp_cons, 200);
        chk(mem[3] == FLOOR + 32'd16, "R3 wrap to floor", mem[3], FLOOR + 32'd16);
        chk(fill_n == f0 + 1 && cmd_args[4] == 32'd24, "R3 wrapped args", cmd_args[4], 32'd24);

        // R1: rejected headers
        do_cfg(32'd8, 32'd8 + 32'd10240, 32'd16, 32'd16);
        push(32'd1, '{32'd1, 32'd1, 32'd1, 32'd1, 32'd0, 32'd0}, 5);
        repeat (60) @(negedge clk);
        chk(mem[3] == 32'd16, "R1 floor inside header", mem[3], 32'd16);
        do_cfg(FLOOR, FLOOR + 32'd10236, FLOOR, FLOOR);
        push(32'd1, '{32'd1, 32'd1, 32'd1, 32'd1, 32'd0, 32'd0}, 5);
        repeat (60) @(negedge clk);
        chk(mem[3] == FLOOR, "R1 span too small", mem[3], FLOOR);
        do_cfg(FLOOR, 32'h10004, FLOOR, FLOOR);
        push(32'd1, '{32'd1, 32'd1, 32'd1, 32'd1, 32'd0, 32'd0}, 5);
        repeat (60) @(negedge clk);
        chk(mem[3] == FLOOR, "R1 ceiling too large", mem[3], FLOOR);
        do_cfg(FLOOR, CEIL, FLOOR + 32'd2, FLOOR);
        push(32'd1, '{32'd1, 32'd1, 32'd1, 32'd1, 32'd0, 32'd0}, 5);
        repeat (60) @(negedge clk);
        chk(mem[3] == FLOOR, "R1 misaligned producer", mem[3], FLOOR);

        // R10: unknown opcode halts with a sticky flag
        do_cfg(FLOOR, CEIL, FLOOR, FLOOR);
        chk(err_flag == 1'b0, "R10 flag clear after config", {31'd0, err_flag}, 32'd0);
        push(32'd7, '{32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}, 1);
        repeat (40) @(negedge clk);
        chk(err_flag == 1'b1, "R10 flag set", {31'd0, err_flag}, 32'd1);
        chk(mem[3] == FLOOR, "R10 consumer not written", mem[3], FLOOR);
        pulse_sync();
        repeat (40) @(negedge clk);
        chk(err_flag == 1'b1 && mem[3] == FLOOR, "R10 halt ignores sync", mem[3], FLOOR);
        do_cfg(FLOOR, CEIL, FLOOR, FLOOR);
        chk(err_flag == 1'b0, "R10 cleared by config edge", {31'd0, err_flag}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule